// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Per-Line Bypass

This block is a second-tier interrupt controller. It samples up to 32 level-sensitive interrupt source lines and drives a small set of combined interrupt outputs into a parent controller. Each combined output has its own build-time group mask that picks the source lines it covers. Some lines also have a bypass gate, set by a build-time forward mask. A forwarded line skips combining and drives its own direct output to the parent.

Software sees two 32-bit registers. Byte offset 0 holds a per-line enable mask that software can read and write. Byte offset 4 holds the synchronized raw level of every line and is read-only. A wired-position mask marks which of the 32 positions have a real source behind them. Positions outside it never reach an output, and they read back as zero. The outputs come straight from flops and no clock gating sits in their path, so an enabled pending line is still signalled to a parent that uses it as a wake source.

Top module: `irq_cascade`

## Requirements
- R1: After reset the enable register reads 0, every combined output and direct output is low, and the status register reads 0 once the inputs have been low for two cycles.
- R2: Combined output g is high when at least one line has all of these: its status bit set, its enable bit set, its bit set in group mask g, its forward bit clear, and its position wired. It follows a change on a source line three clock edges after the change.
- R3: For a forwarded, wired line i, direct_irq[i] copies the synchronized level of the line three edges after a source change. The enable register has no effect on it.
- R4: direct_irq[i] stays low for every line whose forward bit is clear.
- R5: Positions outside the wired mask never raise any output, read as 0 in both registers, and are ignored in the group and forward masks. The default wired mask covers lines 0 to 11.
- R6: A write to byte offset 0 (address bit 2 clear) loads the enable register, keeping wired bits only. A write to byte offset 4 changes nothing. Reads are combinational: offset 0 returns the enable mask and offset 4 returns the status.
- R7: A combined output falls three edges after its last contributing source goes low. It is still high two edges after that change.
- R8: A write to the enable register shows on the combined outputs one edge after the write edge.
- R9: A forwarded line never contributes to a combined output, even when it is enabled and set in that group's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_LINES | Level-sensitive interrupt source lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address (0 = enable, 4 = status) |
| reg_wdata | input | NUM_LINES | Register write data |
| reg_rdata | output | NUM_LINES | Combinational read data for reg_addr |
| agg_irq | output | NUM_GROUPS | Combined interrupt outputs to the parent |
| direct_irq | output | NUM_LINES | Per-line bypass outputs to the parent |

## Verification
A source edge passes through two synchronizer flops and one output flop. The status register therefore changes two edges after a source change, and every output changes three edges after it. An enable write shows on the outputs one edge after the write edge. The bench drives every input on a falling edge and counts rising edges from that point. After a source change it waits exactly three rising edges before it compares outputs, and one rising edge after an enable write. For the fall and enable cases it also samples one edge early, to confirm that the output has not yet changed.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned SEL_BIT    = 2;
  localparam logic        SEL_ENABLE = 1'b0;
  localparam logic        SEL_STATUS = 1'b1;
endpackage

// File: rtl/irq_cascade_sync.sv
module irq_cascade_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign level_o = stage2_q;
endmodule

// File: rtl/irq_cascade_regs.sv
module irq_cascade_regs
  import irq_cascade_pkg::*;
#(
  parameter int unsigned          NUM_LINES  = 32,
  parameter logic [NUM_LINES-1:0] WIRED_MASK = 32'h0000_0FFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] enable_o,
  output logic [NUM_LINES-1:0] reg_rdata
);
  logic [NUM_LINES-1:0] enable_q;
  logic                 sel;

  assign sel = reg_addr[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable_q <= '0;
    else if (reg_we && sel == SEL_ENABLE)
      enable_q <= reg_wdata & WIRED_MASK;
  end

  always_comb begin
    if (sel == SEL_STATUS) reg_rdata = status_i & WIRED_MASK;
    else                   reg_rdata = enable_q;
  end

  assign enable_o = enable_q;

  assert_status_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_STATUS) |=> (enable_q == $past(enable_q)));

  assert_enable_wired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q & ~WIRED_MASK) == '0);
endmodule

// File: rtl/irq_cascade_route.sv
module irq_cascade_route #(
  parameter int unsigned                           NUM_LINES   = 32,
  parameter int unsigned                           NUM_GROUPS  = 2,
  parameter logic [NUM_LINES-1:0]                  WIRED_MASK  = 32'h0000_0FFF,
  parameter logic [NUM_LINES-1:0]                  FWD_MASK    = 32'h0000_0007,
  parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0]  GROUP_MASKS = {32'h0000_0140, 32'h0000_0EB8}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  level_i,
  input  logic [NUM_LINES-1:0]  enable_i,
  output logic [NUM_GROUPS-1:0] agg_o,
  output logic [NUM_LINES-1:0]  direct_o
);
  localparam logic [NUM_LINES-1:0] AGG_ELIGIBLE = WIRED_MASK & ~FWD_MASK;
  localparam logic [NUM_LINES-1:0] DIR_ELIGIBLE = WIRED_MASK & FWD_MASK;

  logic [NUM_LINES-1:0]  active;
  logic [NUM_GROUPS-1:0] hit;
  logic [NUM_GROUPS-1:0] agg_q;
  logic [NUM_LINES-1:0]  direct_q;

  assign active = level_i & enable_i & AGG_ELIGIBLE;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign hit[g] = |(active & GROUP_MASKS[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agg_q    <= '0;
      direct_q <= '0;
    end else begin
      agg_q    <= hit;
      direct_q <= level_i & DIR_ELIGIBLE;
    end
  end

  assign agg_o    = agg_q;
  assign direct_o = direct_q;

  assert_direct_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_q & ~FWD_MASK) == '0);

  assert_direct_unwired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_q & ~WIRED_MASK) == '0);

  assert_direct_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (direct_q == ($past(level_i) & DIR_ELIGIBLE)));

  assert_agg_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|agg_q) |-> $past(|(enable_i & level_i & ~FWD_MASK)));
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_cascade_pkg::*;
#(
  parameter int unsigned                          NUM_LINES   = 32,
  parameter int unsigned                          NUM_GROUPS  = 2,
  parameter logic [NUM_LINES-1:0]                 WIRED_MASK  = 32'h0000_0FFF,
  parameter logic [NUM_LINES-1:0]                 FWD_MASK    = 32'h0000_0007,
  parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0] GROUP_MASKS = {32'h0000_0140, 32'h0000_0EB8}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  src_i,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [NUM_LINES-1:0]  reg_wdata,
  output logic [NUM_LINES-1:0]  reg_rdata,
  output logic [NUM_GROUPS-1:0] agg_irq,
  output logic [NUM_LINES-1:0]  direct_irq
);
  logic [NUM_LINES-1:0] level;
  logic [NUM_LINES-1:0] enable;

  irq_cascade_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i), .level_o(level)
  );

  irq_cascade_regs #(.NUM_LINES(NUM_LINES), .WIRED_MASK(WIRED_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_i(level), .enable_o(enable),
    .reg_rdata(reg_rdata)
  );

  irq_cascade_route #(
    .NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_GROUPS), .WIRED_MASK(WIRED_MASK),
    .FWD_MASK(FWD_MASK), .GROUP_MASKS(GROUP_MASKS)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .level_i(level), .enable_i(enable),
    .agg_o(agg_irq), .direct_o(direct_irq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (agg_irq == '0 && direct_irq == '0));
endmodule

// File: tb/irq_cascade_test.sv
module irq_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  agg_irq;
  logic [31:0] direct_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_cascade #(.GROUP_MASKS({32'h0000_0140, 32'h0000_FEBF})) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .agg_irq(agg_irq), .direct_irq(direct_irq)
  );

  // src, enable, expected agg, expected direct
  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [1:0]  agg;
    logic [31:0] dir;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0FFF, 2'b00, 32'h0},  // R2 idle
    '{32'h0000_0008, 32'h0000_0FFF, 2'b01, 32'h0},  // R2 group 0
    '{32'h0000_0040, 32'h0000_0FFF, 2'b10, 32'h0},  // R2 group 1
    '{32'h0000_0007, 32'h0000_0FFF, 2'b00, 32'h7},  // R9 forwarded lines
    '{32'h0000_0005, 32'h0000_0000, 2'b00, 32'h5},  // R3 enable ignored
    '{32'h0000_0008, 32'h0000_0000, 2'b00, 32'h0},  // R2 disabled
    '{32'hFFFF_F000, 32'hFFFF_FFFF, 2'b00, 32'h0},  // R5 unwired
    '{32'h0000_0900, 32'h0000_0100, 2'b10, 32'h0},  // R2 partial enable
    '{32'h0000_0FFF, 32'h0000_0FFF, 2'b11, 32'h7},  // R2 all
    '{32'h0000_0200, 32'h0000_0200, 2'b01, 32'h0}   // R2 single line
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_check(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    read_check("R1 enable", 3'd0, 32'h0);
    read_check("R1 status", 3'd4, 32'h0);
    check("R1 agg", {30'h0, agg_irq}, 32'h0);
    check("R1 direct", direct_irq, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 agg after release", {30'h0, agg_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_write(3'd0, VECS[i].en);
      src_i = VECS[i].src;
      repeat (3) @(negedge clk);
      check("R2 agg", {30'h0, agg_irq}, {30'h0, VECS[i].agg});
      check("R3 R4 direct", direct_irq, VECS[i].dir);
      read_check("R5 status", 3'd4, VECS[i].src & 32'h0FFF);
      read_check("R6 enable readback", 3'd0, VECS[i].en & 32'h0FFF);
    end

    // R6: status offset write ignored
    reg_write(3'd0, 32'h0000_0123);
    reg_write(3'd4, 32'hFFFF_FFFF);
    read_check("R6 status write ignored", 3'd0, 32'h0000_0123);

    // R8: enable write visible one edge after the write edge
    src_i = 32'h0000_0010;
    reg_write(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    check("R8 precondition", {30'h0, agg_irq}, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_0010;
    @(negedge clk);
    reg_we = 1'b0;
    check("R8 one edge after write", {30'h0, agg_irq}, 32'h0);
    @(negedge clk);
    check("R8 two edges after write", {30'h0, agg_irq}, 32'h1);

    // R7: falls three edges after source drops
    src_i = 32'h0;
    repeat (2) @(negedge clk);
    check("R7 still high", {30'h0, agg_irq}, 32'h1);
    @(negedge clk);
    check("R7 fallen", {30'h0, agg_irq}, 32'h0);

    // R3: forwarded line falls with the same latency
    src_i = 32'h0000_0002;
    repeat (3) @(negedge clk);
    check("R3 direct rise", direct_irq, 32'h2);
    src_i = 32'h0;
    repeat (2) @(negedge clk);
    check("R3 direct hold", direct_irq, 32'h2);
    @(negedge clk);
    check("R3 direct fall", direct_irq, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule